// File: doc/BRIEF.md
# Timestamp Tick Generator and Counter

This block produces the timestamp clock that lets separate crate controllers, each reading out on its own, line up their events afterwards. Its default source is a divide-by-four of the 40 MHz system clock, which gives a 10 MHz tick. A select input can switch the source to an external timestamp clock instead. That external clock is synchronized into the system clock domain and edge-detected, so every register in the block runs on the one system clock. A veto input blocks the tick while it is high. The selected and gated tick is also driven out of the block as a square wave, so that other timestamp modules can count the same clock.

Each accepted tick advances a wide counter, 64 bits by default. The counter is read through a small register port that returns one 16-bit slice per address, zero-extended to a 24-bit word. Reading the least significant slice also stores the whole count in a snapshot register, and the other three addresses read from that snapshot. A carry between two reads therefore cannot tear the assembled value. A synchronous clear input zeros the counter and the divider phase. A sync-enable input holds the counter at zero until counting is allowed to begin.

Top module: `ts_clock_counter`

## Requirements
- R1: With the internal source selected, sync_en high, veto low and clr low, the count rises by one on every fourth system clock, once the divider phase reaches its last state (3 of 0..3).
- R2: While veto is high, the count does not change and tick_out is low.
- R3: When clk_sel equals 1, the count advances once for each rising edge of ext_ts_clk, seen through a two-flop synchronizer followed by an edge detector. Any other clk_sel value selects the internal divider.
- R4: tick_out is high during divider phases 2 and 3 and low during phases 0 and 1, which is a 50% duty square wave at a quarter of the system clock. With the external source selected, tick_out follows the synchronized external level. In both cases veto forces tick_out low.
- R5: A read with rd_en high sets rd_data one clock later. Address 1 returns count bits [SLICE_W-1:0]. Addresses 2, 3 and 4 return snapshot slices 1, 2 and 3, each in the low SLICE_W bits with zeros above. Any other address returns zero. While rd_en is low, rd_data holds its value.
- R6: A read of address 1 copies the full count into the snapshot. Reads of addresses 2 to 4 return that snapshot even after the live count has carried into higher slices.
- R7: A cycle with clr high sets the count and the divider phase to zero at the next edge.
- R8: While sync_en is low, the count is held at zero. After sync_en goes high, counting starts with the next accepted tick.
- R9: After reset, the count, the snapshot, rd_data and tick_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous clear of the count and the divider phase |
| veto | input | 1 | Blocks the tick and forces tick_out low |
| sync_en | input | 1 | Counting allowed; when low, the count is held at zero |
| clk_sel | input | 2 | Source select: 1 = external clock, any other value = internal divider |
| ext_ts_clk | input | 1 | External timestamp clock, asynchronous to clk |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Slice address, 1 to 4 |
| rd_data | output | 24 | Zero-extended slice, registered |
| tick_out | output | 1 | Exported timestamp clock |

## Verification
The hardest case to reach is a snapshot tear: the live count has to carry out of the lowest slice between the read of address 1 and the later reads of the upper addresses. At 64 bits that carry takes far too many ticks, so the bench builds the block with 4-bit slices. It waits until the model count's low slice is all ones and then reads address 1. It lets the carry happen and then reads the upper addresses, which must still show the old snapshot. A fast external clock, toggling every cycle, then pushes the count high enough that the upper slices hold non-zero values.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam logic [1:0] TS_SRC_EXT = 2'd1;
  localparam int         TS_NSLICE  = 4;
endpackage

// File: rtl/ts_tick_gen.sv
module ts_tick_gen #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       veto,
  input  logic [1:0] clk_sel,
  input  logic       ext_ts_clk,
  output logic       tick,
  output logic       tick_out
);
  import ts_pkg::*;
  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(DIV / 2);

  logic [PH_W-1:0] phase_q, phase_d;
  logic [2:0]      ext_q, ext_d;
  logic            use_ext, raw_tick, raw_level;

  assign use_ext = (clk_sel == TS_SRC_EXT);

  always_comb begin
    phase_d = clr ? '0 : ((phase_q == PH_LAST) ? '0 : phase_q + 1'b1);
    ext_d   = {ext_q[1:0], ext_ts_clk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      ext_q   <= '0;
    end else begin
      phase_q <= phase_d;
      ext_q   <= ext_d;
    end
  end

  always_comb begin
    if (use_ext) begin
      raw_tick  = ext_q[1] & ~ext_q[2];
      raw_level = ext_q[1];
    end else begin
      raw_tick  = (phase_q == PH_LAST);
      raw_level = (phase_q >= PH_HALF);
    end
    tick     = raw_tick & ~veto;
    tick_out = raw_level & ~veto;
  end

  // R2: veto silences both the count pulse and the exported clock
  assert_veto_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    veto |-> (!tick && !tick_out));
  // R1: internal ticks never come on back-to-back cycles
  assert_int_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !use_ext && !clr) |=> (!tick || use_ext));
  // R7: clear puts the divider back to phase zero
  assert_phase_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (phase_q == '0));
endmodule

// File: rtl/ts_count_core.sv
module ts_count_core #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sync_en,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | ~sync_en | tick;
    if (clr || !sync_en) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R8: count pinned at zero while sync is off
  assert_hold_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |=> (cnt_q == '0));
  // R7: clear zeros the count
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  // R1: each accepted tick adds exactly one
  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sync_en && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R2: without a tick the count stays put
  assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && sync_en && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/ts_slice_read.sv
module ts_slice_read #(
  parameter int SLICE_W = 16,
  parameter int WORD_W  = 24,
  parameter int ADDR_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             rd_addr,
  input  logic [ts_pkg::TS_NSLICE*SLICE_W-1:0] cnt,
  output logic [WORD_W-1:0]             rd_data
);
  import ts_pkg::*;
  localparam int CNT_W = TS_NSLICE * SLICE_W;
  localparam int PAD_W = WORD_W - SLICE_W;

  logic [CNT_W-1:0]   snap_q, snap_d;
  logic [WORD_W-1:0]  data_q, data_d, sel_word;
  logic [SLICE_W-1:0] snap_slc [TS_NSLICE];
  logic               take_snap;

  for (genvar g = 0; g < TS_NSLICE; g++) begin : g_slc
    assign snap_slc[g] = snap_q[g*SLICE_W +: SLICE_W];
  end

  assign take_snap = rd_en && (rd_addr == ADDR_W'(1));

  always_comb begin
    sel_word = '0;
    if (rd_addr == ADDR_W'(1)) sel_word = {{PAD_W{1'b0}}, cnt[SLICE_W-1:0]};
    for (int i = 1; i < TS_NSLICE; i++) begin
      if (rd_addr == ADDR_W'(i + 1)) sel_word = {{PAD_W{1'b0}}, snap_slc[i]};
    end
    data_d = rd_en ? sel_word : data_q;
    snap_d = take_snap ? cnt : snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      data_q <= '0;
    end else begin
      snap_q <= snap_d;
      data_q <= data_d;
    end
  end

  assign rd_data = data_q;

  // R6: a low-slice read captures the live count
  assert_snapshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_snap |=> (snap_q == $past(cnt)));
  // R6: the snapshot does not move between low-slice reads
  assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !take_snap |=> $stable(snap_q));
  // R5: read data only changes after a strobe
  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(data_q));
endmodule

// File: rtl/ts_clock_counter.sv
module ts_clock_counter #(
  parameter int SLICE_W = 16,
  parameter int WORD_W  = 24,
  parameter int DIV     = 4,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              veto,
  input  logic              sync_en,
  input  logic [1:0]        clk_sel,
  input  logic              ext_ts_clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              tick_out
);
  localparam int CNT_W = ts_pkg::TS_NSLICE * SLICE_W;

  logic             tick;
  logic [CNT_W-1:0] cnt;

  ts_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(clr), .veto(veto), .clk_sel(clk_sel),
    .ext_ts_clk(ext_ts_clk), .tick(tick), .tick_out(tick_out)
  );

  ts_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .clr(clr), .sync_en(sync_en), .tick(tick), .cnt(cnt)
  );

  ts_slice_read #(.SLICE_W(SLICE_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_read (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .cnt(cnt),
    .rd_data(rd_data)
  );

  // R2: a vetoed cycle leaves the count unchanged
  assert_veto_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (veto && !clr && sync_en) |=> $stable(cnt));
endmodule

// File: tb/ts_clock_counter_bench.sv
module ts_clock_counter_bench;
  localparam int SW = 4;
  localparam int WW = 24;
  localparam int CW = 4 * SW;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, veto = 1'b0, sync_en = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic ext_ts_clk = 1'b0, rd_en = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [WW-1:0] rd_data;
  logic tick_out;

  int checks = 0, errors = 0;
  bit chk_to = 1'b0;
  bit done = 1'b0;

  ts_clock_counter #(.SLICE_W(SW), .WORD_W(WW)) u_ts_clock_counter (
    .clk(clk), .rst_n(rst_n), .clr(clr), .veto(veto), .sync_en(sync_en),
    .clk_sel(clk_sel), .ext_ts_clk(ext_ts_clk), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .tick_out(tick_out)
  );

  always #4 clk = ~clk;

  // reference model, built from the requirements
  logic [1:0]    m_ph = '0;
  logic [2:0]    m_ext = '0;
  logic [CW-1:0] m_cnt = '0, m_snap = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      logic tk;
      if (clk_sel == 2'd1) tk = m_ext[1] & ~m_ext[2];
      else                 tk = (m_ph == 2'd3);
      tk = tk & ~veto;
      if (clr || !sync_en) m_cnt = '0;
      else if (tk)         m_cnt = m_cnt + 1'b1;
      m_ph  = clr ? 2'd0 : m_ph + 2'd1;
      m_ext = {m_ext[1:0], ext_ts_clk};
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { logic [WW-1:0] exp; string req; } item_t;
  item_t sb_q[$];
  logic pend = 1'b0;

  always @(posedge clk) pend <= rd_en;

  always @(negedge clk) begin
    if (pend) begin
      if (sb_q.size() == 0) check(1'b0, "R5", rd_data, 0);
      else begin
        item_t it;
        it = sb_q.pop_front();
        check(rd_data == it.exp, it.req, rd_data, it.exp);
      end
    end
    if (rst_n && chk_to) begin
      logic e;
      e = veto ? 1'b0 : ((clk_sel == 2'd1) ? m_ext[1] : (m_ph >= 2'd2));
      check(tick_out == e, veto ? "R2" : "R4", tick_out, e);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [3:0] a, string req);
    item_t it;
    @(negedge clk);
    if (a == 4'd1) begin
      it.exp = WW'(m_cnt[SW-1:0]);
      m_snap = m_cnt;
    end else if (a >= 4'd2 && a <= 4'd4) it.exp = WW'(m_snap[(a-1)*SW +: SW]);
    else it.exp = '0;
    it.req = req;
    sb_q.push_back(it);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    check(rd_data == '0, "R9", rd_data, 0);
    check(tick_out == 1'b0, "R9", tick_out, 0);
    rst_n = 1'b1;
    idle(10);
    rd(4'd1, "R8");              // held at zero with sync_en low
    rd(4'd2, "R9");              // snapshot empty after reset
    chk_to = 1'b1;
    sync_en = 1'b1;
    idle(37);
    rd(4'd1, "R1");
    idle(9);
    rd(4'd1, "R1");
    veto = 1'b1;                 // R2
    idle(20);
    rd(4'd1, "R2");
    veto = 1'b0;
    idle(6);
    rd(4'd1, "R1");
    @(negedge clk); clr = 1'b1;  // R7
    @(negedge clk); clr = 1'b0;
    rd(4'd1, "R7");
    idle(14);
    // R6: snapshot across a carry out of the low slice
    while (m_cnt[SW-1:0] != '1) @(negedge clk);
    rd(4'd1, "R6");
    idle(12);
    rd(4'd2, "R6");
    rd(4'd3, "R6");
    rd(4'd1, "R6");
    rd(4'd2, "R6");
    rd(4'd0, "R5");
    rd(4'd7, "R5");
    // R3: external source, slow then fast
    clk_sel = 2'd1;
    for (int i = 0; i < 10; i++) begin
      ext_ts_clk = 1'b1; idle(3);
      ext_ts_clk = 1'b0; idle(3);
    end
    rd(4'd1, "R3");
    rd(4'd2, "R3");
    for (int i = 0; i < 300; i++) begin
      ext_ts_clk = ~ext_ts_clk; idle(1);
    end
    idle(4);
    rd(4'd1, "R3");
    rd(4'd2, "R5");
    rd(4'd3, "R5");
    rd(4'd4, "R5");
    // R8: sync_en drop and restart
    clk_sel = 2'd2;
    sync_en = 1'b0;
    idle(5);
    rd(4'd1, "R8");
    sync_en = 1'b1;
    idle(11);
    rd(4'd1, "R8");
    idle(4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule